// File: doc/BRIEF.md
# Signaling NaN Detector and Quieter

This combinational single-precision unit inspects one IEEE 754 binary32 operand and reports its class: zero, denormal, normal, infinity, quiet NaN or signaling NaN. When the operand is a signaling NaN, the unit also produces the quiet NaN that replaces it and raises an invalid-operation flag. Every other operand passes through unchanged.

The meaning of the top fraction bit is set at run time by `nan2008_i`. With the flag high, the 2008 convention applies: a set top fraction bit marks a quiet NaN. With the flag low, the legacy convention applies and the polarity is reversed. In legacy mode, clearing the top fraction bit can leave a zero fraction, which would read as infinity. In that case the unit sets the next fraction bit down so that the result stays a NaN.

Top module: `fp_snan_quiet`

## Requirements
- R1: An exponent field of all zeros gives class code 0 (zero) when the fraction is zero, and code 1 (denormal) when the fraction is nonzero.
- R2: An exponent field between 1 and 254 gives class code 2 (normal). An all-ones exponent with a zero fraction gives code 3 (infinity).
- R3: An all-ones exponent with a nonzero fraction is a NaN. It is signaling (code 5) when `nan2008_i` XOR fraction bit 22 equals 1, and quiet (code 4) otherwise.
- R4: `is_snan_o` is high exactly when the class code is 5.
- R5: With `nan2008_i` high, a signaling NaN is quieted by setting fraction bit 22. All other bits stay unchanged.
- R6: With `nan2008_i` low, a signaling NaN is quieted by clearing fraction bit 22. If bits 21..0 are nonzero, all other bits stay unchanged.
- R7: With `nan2008_i` low, if clearing fraction bit 22 leaves a zero fraction, fraction bit 21 is set in the result.
- R8: `invalid_o` is high exactly when the operand is a signaling NaN.
- R9: Any operand that is not a signaling NaN appears unchanged on `result_o`.
- R10: The sign bit and the exponent field of `result_o` always equal those of the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 32 | Operand in binary32 format |
| nan2008_i | input | 1 | 1 selects the 2008 NaN convention, 0 selects the legacy convention |
| class_o | output | 3 | Class code (0 zero, 1 denormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN) |
| is_snan_o | output | 1 | Operand is a signaling NaN |
| result_o | output | 32 | Quieted NaN, or the operand unchanged |
| invalid_o | output | 1 | Invalid-operation flag, raised when a signaling NaN is quieted |

## Verification
The sweep covers every combination of sign, the boundary exponents and the top three fraction bits, each combined with several low-fraction patterns and both modes. The legacy signaling NaN whose only set fraction bit is bit 22 is the critical vector. A design without the repair step would emit infinity there. A design that sets the repair bit unconditionally would corrupt other legacy payloads. A design with the mode polarity swapped would misclass every NaN and quiet the quiet ones. The exponent edges 0, 1, 254 and 255, taken with zero and nonzero fractions, catch designs that confuse zero with denormal, or infinity with NaN.

// File: rtl/nanq_pkg.sv
package nanq_pkg;
  typedef enum logic [2:0] {
    FC_ZERO   = 3'd0,
    FC_DENORM = 3'd1,
    FC_NORMAL = 3'd2,
    FC_INF    = 3'd3,
    FC_QNAN   = 3'd4,
    FC_SNAN   = 3'd5
  } fp_class_e;
endpackage

// File: rtl/nanq_classify.sv
module nanq_classify
  import nanq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  input  logic                  nan2008_i,
  output fp_class_e             class_o,
  output logic                  is_snan_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_zero, exp_ones, frac_zero, is_nan;

  assign exp_f     = op_i[FRAC_W +: EXP_W];
  assign frac_f    = op_i[FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = &exp_f;
  assign frac_zero = (frac_f == '0);
  assign is_nan    = exp_ones && !frac_zero;
  // signaling when the mode bit and the kind bit differ
  assign is_snan_o = is_nan && (nan2008_i ^ frac_f[FRAC_W-1]);

  always_comb begin
    if (exp_zero)       class_o = frac_zero ? FC_ZERO : FC_DENORM;
    else if (!exp_ones) class_o = FC_NORMAL;
    else if (frac_zero) class_o = FC_INF;
    else if (is_snan_o) class_o = FC_SNAN;
    else                class_o = FC_QNAN;
  end
endmodule

// File: rtl/nanq_quiet.sv
module nanq_quiet #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  input  logic                  snan_i,
  input  logic                  nan2008_i,
  output logic [EXP_W+FRAC_W:0] result_o,
  output logic                  invalid_o
);
  localparam int KIND_B = FRAC_W - 1;
  localparam int FIX_B  = FRAC_W - 2;

  logic [FRAC_W-1:0] frac_in, frac_q;

  assign frac_in = op_i[FRAC_W-1:0];

  always_comb begin
    frac_q = frac_in;
    if (nan2008_i) begin
      frac_q[KIND_B] = 1'b1;
    end else begin
      frac_q[KIND_B] = 1'b0;
      // keep the payload from collapsing into an infinity pattern
      if (frac_q == '0) frac_q[FIX_B] = 1'b1;
    end
  end

  assign result_o  = snan_i ? {op_i[EXP_W+FRAC_W:FRAC_W], frac_q} : op_i;
  assign invalid_o = snan_i;
endmodule

// File: rtl/fp_snan_quiet.sv
module fp_snan_quiet
  import nanq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  input  logic                  nan2008_i,
  output logic [2:0]            class_o,
  output logic                  is_snan_o,
  output logic [EXP_W+FRAC_W:0] result_o,
  output logic                  invalid_o
);
  fp_class_e cls;
  logic      snan;

  nanq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .op_i      (op_i),
    .nan2008_i (nan2008_i),
    .class_o   (cls),
    .is_snan_o (snan)
  );

  nanq_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
    .op_i      (op_i),
    .snan_i    (snan),
    .nan2008_i (nan2008_i),
    .result_o  (result_o),
    .invalid_o (invalid_o)
  );

  assign class_o   = cls;
  assign is_snan_o = snan;
endmodule

// File: rtl/nanq_checker.sv
module nanq_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic [EXP_W+FRAC_W:0] op_i,
  input logic                  nan2008_i,
  input logic [2:0]            class_o,
  input logic                  is_snan_o,
  input logic [EXP_W+FRAC_W:0] result_o,
  input logic                  invalid_o
);
  localparam int W = EXP_W + FRAC_W + 1;

  always_comb begin
    AST_SNAN_CLASS: assert (is_snan_o == (class_o == 3'd5)) else $error("snan/class");  // R4
    AST_INVALID_SNAN: assert (invalid_o == is_snan_o) else $error("invalid");          // R8
    AST_PASS_THRU: assert (invalid_o || result_o == op_i) else $error("pass");         // R9
    AST_HDR_KEPT: assert (result_o[W-1:FRAC_W] == op_i[W-1:FRAC_W]) else $error("hdr"); // R10
    AST_STILL_NAN: assert (!invalid_o || (result_o[FRAC_W-1:0] != '0))
      else $error("became inf");                                                        // R7
    AST_NOW_QUIET: assert (!invalid_o || !(nan2008_i ^ result_o[FRAC_W-1]))
      else $error("not quiet");                                                         // R5
  end
endmodule

bind fp_snan_quiet nanq_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .op_i      (op_i),
  .nan2008_i (nan2008_i),
  .class_o   (class_o),
  .is_snan_o (is_snan_o),
  .result_o  (result_o),
  .invalid_o (invalid_o)
);

// File: tb/sim_fp_snan_quiet.sv
module sim_fp_snan_quiet;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] op;
  logic        mode;
  logic [2:0]  cls;
  logic        snan, inv;
  logic [31:0] res;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_snan_quiet u0 (
    .op_i(op), .nan2008_i(mode), .class_o(cls),
    .is_snan_o(snan), .result_o(res), .invalid_o(inv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%h mode=%0d act=%h exp=%h", req, op, mode, act, exp_v);
    end
  endtask

  task automatic apply(input logic [31:0] v, input logic m);
    logic [7:0]  e;
    logic [22:0] f, fq;
    logic        is_nan, is_s;
    logic [2:0]  ec;
    logic [31:0] er;
    @(posedge clk);
    op = v; mode = m;
    @(negedge clk);
    e = v[30:23]; f = v[22:0];
    is_nan = (e == 8'hFF) && (f != 0);
    is_s = is_nan && (m != f[22]);
    if (e == 0)          ec = (f == 0) ? 3'd0 : 3'd1;
    else if (e != 8'hFF) ec = 3'd2;
    else if (f == 0)     ec = 3'd3;
    else                 ec = is_s ? 3'd5 : 3'd4;
    fq = f;
    if (m) fq[22] = 1'b1;
    else begin
      fq[22] = 1'b0;
      if (fq == 0) fq[21] = 1'b1;
    end
    er = is_s ? {v[31:23], fq} : v;
    if (e == 0)               chk("R1 class", {29'd0, cls}, {29'd0, ec});
    else if (!is_nan)         chk("R2 class", {29'd0, cls}, {29'd0, ec});
    else                      chk("R3 class", {29'd0, cls}, {29'd0, ec});
    chk("R4 snan flag", {31'd0, snan}, {31'd0, is_s});
    chk("R8 invalid", {31'd0, inv}, {31'd0, is_s});
    if (!is_s)                 chk("R9 passthru", res, er);
    else if (m)                chk("R5 quiet2008", res, er);
    else if (f[21:0] == 0)     chk("R7 repair", res, er);
    else                       chk("R6 quietlegacy", res, er);
    chk("R10 sign/exp", {23'd0, res[31:23]}, {23'd0, v[31:23]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  exps [6];
    logic [19:0] lows [4];
    exps[0] = 8'h00; exps[1] = 8'h01; exps[2] = 8'h7F;
    exps[3] = 8'hFE; exps[4] = 8'hFF; exps[5] = 8'h80;
    lows[0] = 20'h0; lows[1] = 20'h1; lows[2] = 20'hA5C3E; lows[3] = 20'hFFFFF;
    op = '0; mode = 1'b0;
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int ei = 0; ei < 6; ei++)
          for (int t = 0; t < 8; t++)
            for (int li = 0; li < 4; li++)
              apply({s[0], exps[ei], t[2:0], lows[li]}, m[0]);
    // both lone-bit legacy repairs explicitly
    apply(32'h7FC0_0000, 1'b0);
    apply(32'hFFC0_0000, 1'b0);
    apply(32'h7F80_0001, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule